// File: doc/BRIEF.md
# Exception and Status Control Unit

This block is the system-control register set of a small 32-bit in-order RISC core. It holds the status word with its three-deep kernel/user and interrupt-enable stack, the cause word, the exception return address, a fixed processor identity and a bank of debug breakpoint registers. The pipeline reports faults to it. Each fault comes with a 5-bit code, the address of the instruction and a flag that says whether that instruction sat in a branch delay slot. The block answers one cycle later with a flush pulse and the vector address at which fetch must restart.

Software reaches the registers through move-to and move-from commands that use a 5-bit index. Reads are combinational from the index. Writes take effect at the next clock edge and change only the writable bits of each register. A return-from-exception command pops the mode stack. Any of these commands issued in user mode while the coprocessor-0 enable bit is clear does not execute. It raises a coprocessor-unusable exception instead.

Top module: `sysctl_unit`

## Requirements
- R1: On exception entry the return-address register (index 14) takes the instruction address. When the delay-slot flag is set it takes that address minus 4.
- R2: On exception entry cause bits [6:2] take the exception code and cause bit 31 takes the delay-slot flag. All other cause bits keep their values.
- R3: Status bits [5:0] hold three mode pairs, each pair written as {KU at the odd bit, IE at the even bit}: current in [1:0], previous in [3:2], old in [5:4]. Exception entry moves the field two places up and clears [1:0].
- R4: In the cycle after an exception is taken, `flush` is high for exactly one cycle. At the same time `redirect_pc` is 0xBFC00180 if status bit 22 was set when the exception was taken, and 0x80000080 otherwise.
- R5: Return-from-exception keeps status bits [5:4] and loads bits [3:0] from bits [5:2].
- R6: A move-to status (index 12) changes only the bits set in 0xF27FFF3F.
- R7: A move-to cause (index 13) changes only bits [9:8].
- R8: Writes to indices 14, 8, 15 and 6 are ignored. Index 15 always reads 0x00000002, and indices 8 and 6 read zero.
- R9: When status bit 1 (user mode) is set and status bit 28 is clear, a move-to, move-from or return-from-exception command does not execute. An exception with code 11 is taken instead.
- R10: Indices 3, 5, 7, 9 and 11 are plain 32-bit read/write registers. An unmapped index reads zero.
- R11: If an exception request and a return-from-exception or move-to command arrive in the same cycle, the exception is taken and the command is dropped.
- R12: After reset, status reads 0x00400000, cause, return address and breakpoint registers read zero, and `flush` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Pipeline exception request |
| exc_code | input | 5 | Exception code of the request |
| inst_pc | input | 32 | Address of the faulting or issuing instruction |
| inst_in_delay | input | 1 | Instruction sits in a branch delay slot |
| cmd_mtc | input | 1 | Move-to register command |
| cmd_mfc | input | 1 | Move-from register command (used for the permission check only) |
| cmd_rfe | input | 1 | Return-from-exception command |
| reg_idx | input | 5 | Register index for move commands |
| reg_wdata | input | 32 | Move-to data |
| reg_rdata | output | 32 | Move-from data for `reg_idx` |
| flush | output | 1 | Pipeline flush pulse |
| redirect_pc | output | 32 | Fetch restart address, valid with `flush` |

## Verification
A corrupted mode stack shows up as a wrong status read straight after the push or pop. It also changes the permission decision for the next command, so a lost user bit lets a forbidden write land in a breakpoint register where a read can see it. A wrong return-address adjustment or a wrong vector choice is visible at the first negative edge after the exception edge, through index 14 and `redirect_pc`. Arbitration errors between a fault and a same-cycle command appear as a status low field that a pop would produce where a push was expected.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int XLEN   = 32;
    localparam int IDX_W  = 5;
    localparam int CODE_W = 5;
    localparam int MODE_W = 6;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam idx_t IDX_JUMP    = 5'd6;
    localparam idx_t IDX_BADADDR = 5'd8;
    localparam idx_t IDX_STAT    = 5'd12;
    localparam idx_t IDX_CAUSE   = 5'd13;
    localparam idx_t IDX_RETPC   = 5'd14;
    localparam idx_t IDX_IDENT   = 5'd15;

    localparam int BEV_BIT   = 22;
    localparam int CU0_BIT   = 28;
    localparam int USER_BIT  = 1;
    localparam int BD_BIT    = 31;
    localparam int CODE_LSB  = 2;

    localparam word_t STAT_WMASK  = 32'hF27F_FF3F;
    localparam word_t CAUSE_WMASK = 32'h0000_0300;
    localparam word_t STAT_RESET  = 32'h0040_0000;
    localparam word_t IDENT_VALUE = 32'h0000_0002;
    localparam word_t VEC_BOOT    = 32'hBFC0_0180;
    localparam word_t VEC_RUN     = 32'h8000_0080;
    localparam word_t INSN_BYTES  = 32'd4;

    localparam code_t CODE_COP_UNUSABLE = 5'd11;

    localparam int NUM_BKPT = 5;

    typedef struct packed {
        logic  valid;
        code_t code;
        word_t pc;
        logic  in_delay;
    } exc_evt_t;

    function automatic idx_t bkpt_index(input int i);
        case (i)
            0:       return 5'd3;
            1:       return 5'd5;
            2:       return 5'd7;
            3:       return 5'd9;
            default: return 5'd11;
        endcase
    endfunction

    function automatic word_t masked_merge(input word_t old_v, input word_t new_v, input word_t mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic [MODE_W-1:0] mode_push(input logic [MODE_W-1:0] m);
        return {m[MODE_W-3:0], 2'b00};
    endfunction

    function automatic logic [MODE_W-1:0] mode_pop(input logic [MODE_W-1:0] m);
        return {m[MODE_W-1:MODE_W-2], m[MODE_W-1:2]};
    endfunction

endpackage

// File: rtl/sc_status.sv
module sc_status
    import sysctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  logic  do_pop,
    input  logic  wr_en,
    input  word_t wdata,
    output word_t stat
);

    word_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= STAT_RESET;
        end else if (take) begin
            stat_q[MODE_W-1:0] <= mode_push(stat_q[MODE_W-1:0]);
        end else if (do_pop) begin
            stat_q[MODE_W-1:0] <= mode_pop(stat_q[MODE_W-1:0]);
        end else if (wr_en) begin
            stat_q <= masked_merge(stat_q, wdata, STAT_WMASK);
        end
    end

    assign stat = stat_q;

    // R3
    mode_push_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (stat_q[3:2] == $past(stat_q[1:0])) && (stat_q[5:4] == $past(stat_q[3:2]))
                 && (stat_q[1:0] == 2'b00));

    // R5
    mode_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !take) |=> (stat_q[5:4] == $past(stat_q[5:4])) && (stat_q[1:0] == $past(stat_q[3:2])));

    // R6
    stat_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !take && !do_pop) |=> ((stat_q & ~STAT_WMASK) == $past(stat_q & ~STAT_WMASK)));

endmodule

// File: rtl/sc_cause.sv
module sc_cause
    import sysctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  exc_evt_t evt,
    input  logic     wr_en,
    input  word_t    wdata,
    output word_t    cause,
    output word_t    retpc
);

    word_t cause_q;
    word_t retpc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            retpc_q <= '0;
        end else if (evt.valid) begin
            retpc_q <= evt.in_delay ? (evt.pc - INSN_BYTES) : evt.pc;
            cause_q[CODE_LSB +: CODE_W] <= evt.code;
            cause_q[BD_BIT]             <= evt.in_delay;
        end else if (wr_en) begin
            cause_q <= masked_merge(cause_q, wdata, CAUSE_WMASK);
        end
    end

    assign cause = cause_q;
    assign retpc = retpc_q;

    // R1
    retpc_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !evt.in_delay) |=> (retpc_q == $past(evt.pc)));

    // R1
    retpc_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.in_delay) |=> (retpc_q + INSN_BYTES == $past(evt.pc)));

    // R2
    cause_bd_chk: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> (cause_q[BD_BIT] == $past(evt.in_delay)) && (cause_q[9:8] == $past(cause_q[9:8])));

    // R7
    cause_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !evt.valid) |=> ((cause_q & ~CAUSE_WMASK) == $past(cause_q & ~CAUSE_WMASK)));

endmodule

// File: rtl/sc_bkpt_bank.sv
module sc_bkpt_bank
    import sysctl_pkg::*;
#(
    parameter int N = NUM_BKPT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  idx_t  idx,
    input  word_t wdata,
    output logic  hit,
    output word_t rdata
);

    word_t slot_q [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (wr_en && idx == bkpt_index(i)) begin
                slot_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        hit   = 1'b0;
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (idx == bkpt_index(i)) begin
                hit   = 1'b1;
                rdata = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
    import sysctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        exc_req,
    input  logic [4:0]  exc_code,
    input  logic [31:0] inst_pc,
    input  logic        inst_in_delay,
    input  logic        cmd_mtc,
    input  logic        cmd_mfc,
    input  logic        cmd_rfe,
    input  logic [4:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        flush,
    output logic [31:0] redirect_pc
);

    word_t    stat, cause, retpc, bk_val;
    logic     bk_hit;
    logic     any_cmd, denied, take, do_wr, do_pop;
    exc_evt_t evt;
    logic     flush_q;
    word_t    redirect_q;

    assign any_cmd = cmd_mtc | cmd_mfc | cmd_rfe;
    assign denied  = any_cmd & stat[USER_BIT] & ~stat[CU0_BIT];
    assign take    = exc_req | denied;
    assign do_wr   = cmd_mtc & ~take;
    assign do_pop  = cmd_rfe & ~take;

    always_comb begin
        evt.valid    = take;
        evt.code     = exc_req ? exc_code : CODE_COP_UNUSABLE;
        evt.pc       = inst_pc;
        evt.in_delay = inst_in_delay;
    end

    sc_status u_status (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .do_pop (do_pop),
        .wr_en  (do_wr && reg_idx == IDX_STAT),
        .wdata  (reg_wdata),
        .stat   (stat)
    );

    sc_cause u_cause (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .wr_en (do_wr && reg_idx == IDX_CAUSE),
        .wdata (reg_wdata),
        .cause (cause),
        .retpc (retpc)
    );

    sc_bkpt_bank #(.N(NUM_BKPT)) u_bkpt (
        .clk   (clk),
        .rst   (rst),
        .wr_en (do_wr),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .hit   (bk_hit),
        .rdata (bk_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_q    <= 1'b0;
            redirect_q <= '0;
        end else begin
            flush_q <= take;
            if (take) begin
                redirect_q <= stat[BEV_BIT] ? VEC_BOOT : VEC_RUN;
            end
        end
    end

    always_comb begin
        case (reg_idx)
            IDX_STAT:    reg_rdata = stat;
            IDX_CAUSE:   reg_rdata = cause;
            IDX_RETPC:   reg_rdata = retpc;
            IDX_IDENT:   reg_rdata = IDENT_VALUE;
            IDX_BADADDR: reg_rdata = '0;
            IDX_JUMP:    reg_rdata = '0;
            default:     reg_rdata = bk_hit ? bk_val : '0;
        endcase
    end

    assign flush       = flush_q;
    assign redirect_pc = redirect_q;

    // R4
    flush_follow_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> flush && (redirect_pc == ($past(stat[BEV_BIT]) ? VEC_BOOT : VEC_RUN)));

    // R4
    flush_single_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> !flush);

    // R9
    unusable_code_chk: assert property (@(posedge clk) disable iff (rst)
        (denied && !exc_req) |=> (cause[CODE_LSB +: CODE_W] == CODE_COP_UNUSABLE));

    // R11
    exc_beats_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && cmd_rfe) |=> (stat[5:2] == $past(stat[3:0])));

    // R8
    ident_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_idx == IDX_IDENT) |-> (reg_rdata == IDENT_VALUE));

endmodule

// File: tb/sim_sysctl_unit.sv
module sim_sysctl_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req, inst_in_delay, cmd_mtc, cmd_mfc, cmd_rfe;
    logic [4:0]  exc_code, reg_idx;
    logic [31:0] inst_pc, reg_wdata, reg_rdata, redirect_pc;
    logic        flush;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_unit u0 (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
        .inst_pc(inst_pc), .inst_in_delay(inst_in_delay),
        .cmd_mtc(cmd_mtc), .cmd_mfc(cmd_mfc), .cmd_rfe(cmd_rfe),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flush(flush), .redirect_pc(redirect_pc)
    );

    task automatic idle_inputs();
        exc_req = 0; exc_code = 0; inst_pc = 0; inst_in_delay = 0;
        cmd_mtc = 0; cmd_mfc = 0; cmd_rfe = 0; reg_idx = 0; reg_wdata = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [4:0] idx, input logic [31:0] exp);
        reg_idx = idx;
        #1;
        check(tag, reg_rdata, exp);
        reg_idx = 0;
    endtask

    task automatic write_reg(input logic [4:0] idx, input logic [31:0] val);
        cmd_mtc = 1; reg_idx = idx; reg_wdata = val; inst_pc = 32'h0000_4000;
        tick();
    endtask

    task automatic raise(input logic [4:0] code, input logic [31:0] pc, input logic dly);
        exc_req = 1; exc_code = code; inst_pc = pc; inst_in_delay = dly;
        tick();
    endtask

    task automatic t_reset();
        check("R12 flush", {31'd0, flush}, 32'd0);
        read_chk("R12 status", 5'd12, 32'h0040_0000);
        read_chk("R12 cause", 5'd13, 32'h0);
        read_chk("R12 retpc", 5'd14, 32'h0);
        read_chk("R12 bkpt", 5'd3, 32'h0);
        read_chk("R8 badaddr", 5'd8, 32'h0);
        read_chk("R8 ident", 5'd15, 32'h0000_0002);
    endtask

    task automatic t_plain_exception();
        write_reg(5'd12, 32'h0000_0003);
        read_chk("R6 status set", 5'd12, 32'h0000_0003);
        raise(5'd8, 32'h8000_1000, 1'b0);
        check("R4 flush", {31'd0, flush}, 32'd1);
        check("R4 vector run", redirect_pc, 32'h8000_0080);
        read_chk("R1 retpc", 5'd14, 32'h8000_1000);
        read_chk("R2 cause", 5'd13, 32'h0000_0020);
        read_chk("R3 push", 5'd12, 32'h0000_000C);
        tick();
        check("R4 pulse ends", {31'd0, flush}, 32'd0);
    endtask

    task automatic t_slot_exception();
        write_reg(5'd12, 32'h0040_000C);
        write_reg(5'd13, 32'h0000_0300);
        read_chk("R7 cause sw bits", 5'd13, 32'h0000_0320);
        raise(5'd4, 32'h0000_0100, 1'b1);
        check("R4 vector boot", redirect_pc, 32'hBFC0_0180);
        read_chk("R1 retpc slot", 5'd14, 32'h0000_00FC);
        read_chk("R2 cause slot", 5'd13, 32'h8000_0310);
        read_chk("R3 push twice", 5'd12, 32'h0040_0030);
    endtask

    task automatic t_pop();
        cmd_rfe = 1; inst_pc = 32'h0000_0200;
        tick();
        read_chk("R5 pop", 5'd12, 32'h0040_003C);
        check("R5 no flush", {31'd0, flush}, 32'd0);
    endtask

    task automatic t_masks();
        write_reg(5'd12, 32'hFFFF_FFFF);
        read_chk("R6 all ones", 5'd12, 32'hF27F_FF3F);
        write_reg(5'd13, 32'hFFFF_FFFF);
        read_chk("R7 all ones", 5'd13, 32'h8000_0310);
        write_reg(5'd13, 32'h0000_0000);
        read_chk("R7 zeros", 5'd13, 32'h8000_0010);
        write_reg(5'd12, 32'h0000_0000);
        read_chk("R6 zeros", 5'd12, 32'h0000_0000);
    endtask

    task automatic t_ignored();
        write_reg(5'd14, 32'hDEAD_BEEF);
        write_reg(5'd8, 32'h1111_1111);
        write_reg(5'd15, 32'h2222_2222);
        write_reg(5'd6, 32'h3333_3333);
        read_chk("R8 retpc kept", 5'd14, 32'h0000_00FC);
        read_chk("R8 badaddr kept", 5'd8, 32'h0);
        read_chk("R8 ident kept", 5'd15, 32'h0000_0002);
        read_chk("R8 jump kept", 5'd6, 32'h0);
    endtask

    task automatic t_bkpt();
        for (int i = 0; i < 5; i++) write_reg(5'(3 + 2 * i), 32'hA000_0000 + 32'(i));
        for (int i = 0; i < 5; i++) read_chk("R10 bkpt", 5'(3 + 2 * i), 32'hA000_0000 + 32'(i));
        read_chk("R10 unmapped", 5'd20, 32'h0);
    endtask

    task automatic t_unusable();
        write_reg(5'd12, 32'h0000_0002);
        cmd_mtc = 1; reg_idx = 5'd3; reg_wdata = 32'h0000_1234; inst_pc = 32'h0000_2000;
        tick();
        check("R9 flush", {31'd0, flush}, 32'd1);
        check("R9 vector", redirect_pc, 32'h8000_0080);
        read_chk("R9 write dropped", 5'd3, 32'hA000_0000);
        read_chk("R9 cause", 5'd13, 32'h0000_002C);
        read_chk("R9 retpc", 5'd14, 32'h0000_2000);
        read_chk("R9 push", 5'd12, 32'h0000_0008);
        cmd_rfe = 1;
        tick();
        read_chk("R5 back to user", 5'd12, 32'h0000_0002);
        cmd_rfe = 1; inst_pc = 32'h0000_2100;
        tick();
        check("R9 rfe denied flush", {31'd0, flush}, 32'd1);
        read_chk("R9 rfe denied", 5'd12, 32'h0000_0008);
        write_reg(5'd12, 32'h1000_0002);
        write_reg(5'd3, 32'h0000_0055);
        check("R9 enabled no flush", {31'd0, flush}, 32'd0);
        read_chk("R9 enabled write", 5'd3, 32'h0000_0055);
    endtask

    task automatic t_priority();
        exc_req = 1; exc_code = 5'd12; inst_pc = 32'h0000_3000; cmd_rfe = 1;
        tick();
        read_chk("R11 push wins", 5'd12, 32'h1000_0008);
        read_chk("R11 cause", 5'd13, 32'h0000_0030);
        exc_req = 1; exc_code = 5'd9; inst_pc = 32'h0000_3100;
        cmd_mtc = 1; reg_idx = 5'd5; reg_wdata = 32'h0BAD_0BAD;
        tick();
        read_chk("R11 write dropped", 5'd5, 32'hA000_0001);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_plain_exception();
        t_slot_exception();
        t_pop();
        t_masks();
        t_ignored();
        t_bkpt();
        t_unusable();
        t_priority();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule